// File: doc/BRIEF.md
# Lane Code Group Sync Controller

This block sits on the receive side of a multi-lane serial converter link and owns the active-low synchronization request line that runs back to the transmitter. It watches the decoded octet stream of one lane, one octet per link clock, and holds the request line low until the lane has seen a long enough unbroken run of comma control characters. Releasing the line high is the handshake that tells the transmitter to stop sending commas and start its alignment sequence.

Once locked, the block watches the decode-error flag. A run of errored octets drops the lane back to hunting, and a re-sync request input does the same at once. In both cases the request line goes low again. A status output reports whether the lane counts as synchronized. Every output comes from a register clocked by the link clock.

Top module: `lane_sync_ctrl`

## Requirements
- R1: While reset is applied, and after its release until lock is reached, `sync_n` and `lane_synced` are both 0.
- R2: A comma is a cycle with `oct_vld`=1, `oct_ctl`=1, `oct_data`=8'hBC and `dec_err`=0. The value 8'hBC with `oct_ctl`=0, or with `dec_err`=1, is not a comma.
- R3: While hunting, `sync_n` and `lane_synced` go to 1 on the clock edge that samples the COMMA_MIN-th consecutive comma (default 4). Three consecutive commas do not lock the lane.
- R4: While hunting, any valid octet that is not a comma clears the comma run. For example, 8'h1C with `oct_ctl`=1 or plain data both clear it.
- R5: Cycles with `oct_vld`=0 neither advance nor break the comma run or the error run, and they never change the outputs.
- R6: While locked, commas, control characters and data octets without `dec_err` keep `sync_n` at 1.
- R7: `resync_req`=1 forces both outputs to 0 on the next edge. They stay 0 for as long as it is held, and commas seen during that time are not counted.
- R8: While locked, ERR_LIMIT consecutive valid octets with `dec_err`=1 (default 4) drop both outputs to 0 on the edge that samples the last one. A valid octet without `dec_err` restarts that run.
- R9: After any loss of lock, a fresh run of COMMA_MIN commas is needed to lock again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Link clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| oct_vld | input | 1 | Decoded octet present this cycle |
| oct_ctl | input | 1 | Octet is a control character |
| oct_data | input | 8 | Decoded octet value |
| dec_err | input | 1 | Decoder reported an error on this octet |
| resync_req | input | 1 | Request to restart synchronization |
| sync_n | output | 1 | Active-low sync request to transmitter (1 = synchronized) |
| lane_synced | output | 1 | Lane synchronized status |

## Verification
The assertions assume that the decoder inputs change only between clock edges and that `sync_n` can change only in response to a sampled comma, error octet or re-sync request. They also assume that a cycle with nothing valid and no re-sync leaves the line alone. The stimulus drives every input on the falling edge and keeps reset asserted across several edges. After release it idles with `oct_vld` low until the internal reset synchronizer has let go, so the first counted octet is never lost to the release delay.

// File: rtl/lsync_pkg.sv
package lsync_pkg;
  typedef enum logic {
    LS_HUNT   = 1'b0,
    LS_LOCKED = 1'b1
  } lsync_state_e;

  localparam logic [7:0] COMMA_CODE = 8'hBC;
endpackage

// File: rtl/lsync_rst_sync.sv
module lsync_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ni
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_ni = chain_q[STAGES-1];
endmodule

// File: rtl/lsync_run_cnt.sv
module lsync_run_cnt #(
  parameter int LIMIT = 4,
  localparam int CW = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic clr,
  input  logic inc,
  output logic hit
);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign hit = inc && !clr && (cnt_q == LAST);

  always_comb begin
    cnt_en = clr || inc;
    cnt_d  = cnt_q;
    if (clr || hit) begin
      cnt_d = '0;
    end else if (inc) begin
      cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/lsync_fsm.sv
module lsync_fsm
  import lsync_pkg::*;
(
  input  logic         clk,
  input  logic         rst_ni,
  input  logic         resync,
  input  logic         comma_hit,
  input  logic         err_hit,
  output lsync_state_e state,
  output logic         locked_q
);
  lsync_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (resync) begin
      state_d = LS_HUNT;
    end else begin
      case (state_q)
        LS_HUNT:   if (comma_hit) state_d = LS_LOCKED;
        LS_LOCKED: if (err_hit)   state_d = LS_HUNT;
        default:   state_d = LS_HUNT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= LS_HUNT;
      locked_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      locked_q <= (state_d == LS_LOCKED);
    end
  end

  assign state = state_q;
endmodule

// File: rtl/lane_sync_ctrl.sv
module lane_sync_ctrl
  import lsync_pkg::*;
#(
  parameter int COMMA_MIN  = 4,
  parameter int ERR_LIMIT  = 4,
  parameter int RST_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       oct_vld,
  input  logic       oct_ctl,
  input  logic [7:0] oct_data,
  input  logic       dec_err,
  input  logic       resync_req,
  output logic       sync_n,
  output logic       lane_synced
);
  logic         rst_ni;
  lsync_state_e state;
  logic         locked_q;
  logic         is_comma, hunting, locked;
  logic         comma_inc, comma_clr, comma_hit;
  logic         err_inc, err_clr, err_hit;

  lsync_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_ni (rst_ni)
  );

  assign is_comma = oct_ctl && !dec_err && (oct_data == COMMA_CODE);
  assign hunting  = (state == LS_HUNT);
  assign locked   = (state == LS_LOCKED);

  assign comma_inc = hunting && oct_vld && is_comma;
  assign comma_clr = resync_req || !hunting || (oct_vld && !is_comma);
  assign err_inc   = locked && oct_vld && dec_err;
  assign err_clr   = resync_req || !locked || (oct_vld && !dec_err);

  lsync_run_cnt #(.LIMIT(COMMA_MIN)) u_comma_run (
    .clk    (clk),
    .rst_ni (rst_ni),
    .clr    (comma_clr),
    .inc    (comma_inc),
    .hit    (comma_hit)
  );

  lsync_run_cnt #(.LIMIT(ERR_LIMIT)) u_err_run (
    .clk    (clk),
    .rst_ni (rst_ni),
    .clr    (err_clr),
    .inc    (err_inc),
    .hit    (err_hit)
  );

  lsync_fsm u_fsm (
    .clk       (clk),
    .rst_ni    (rst_ni),
    .resync    (resync_req),
    .comma_hit (comma_hit),
    .err_hit   (err_hit),
    .state     (state),
    .locked_q  (locked_q)
  );

  assign sync_n      = locked_q;
  assign lane_synced = locked_q;
endmodule

// File: rtl/lane_sync_chk.sv
module lane_sync_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       oct_vld,
  input logic       oct_ctl,
  input logic [7:0] oct_data,
  input logic       dec_err,
  input logic       resync_req,
  input logic       sync_n,
  input logic       lane_synced
);
  // R3 / R2: a rise must follow a sampled comma with no re-sync
  a_r3_rise_on_comma: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_n) |-> $past(oct_vld && oct_ctl && !dec_err && oct_data == 8'hBC && !resync_req));

  // R7: re-sync forces the line low next cycle
  a_r7_resync_low: assert property (@(posedge clk) disable iff (!rst_n)
    resync_req |=> (!sync_n && !lane_synced));

  // R5: idle cycles leave the outputs unchanged
  a_r5_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!oct_vld && !resync_req) |=> ($stable(sync_n) && $stable(lane_synced)));

  // R8: a fall needs an errored octet or a re-sync
  a_r8_fall_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sync_n) |-> $past(resync_req || (oct_vld && dec_err)));

  // R6: clean valid octets never drop a locked lane
  a_r6_clean_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_n && oct_vld && !dec_err && !resync_req) |=> sync_n);
endmodule

bind lane_sync_ctrl lane_sync_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .oct_vld     (oct_vld),
  .oct_ctl     (oct_ctl),
  .oct_data    (oct_data),
  .dec_err     (dec_err),
  .resync_req  (resync_req),
  .sync_n      (sync_n),
  .lane_synced (lane_synced)
);

// File: tb/lane_sync_ctrl_tb_top.sv
`timescale 1ns/1ps
module lane_sync_ctrl_tb_top;
  logic       clk;
  logic       rst_n;
  logic       oct_vld, oct_ctl, dec_err, resync_req;
  logic [7:0] oct_data;
  logic       sync_n, lane_synced;

  int total = 0;
  int bad   = 0;
  int cycles = 0;
  string tag = "R1";

  // behavioural reference state
  bit m_lock = 0;
  int m_commas = 0;
  int m_errs = 0;

  lane_sync_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .oct_vld(oct_vld), .oct_ctl(oct_ctl),
    .oct_data(oct_data), .dec_err(dec_err), .resync_req(resync_req),
    .sync_n(sync_n), .lane_synced(lane_synced)
  );

  initial clk = 0;
  always #5 clk = ~clk;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_lock = 0; m_commas = 0; m_errs = 0;
    end else if (resync_req) begin
      m_lock = 0; m_commas = 0; m_errs = 0;
    end else if (!m_lock) begin
      if (oct_vld) begin
        if (oct_ctl && !dec_err && oct_data == 8'hBC) begin
          m_commas++;
          if (m_commas >= 4) begin m_lock = 1; m_commas = 0; end
        end else m_commas = 0;
      end
    end else if (oct_vld) begin
      if (dec_err) begin
        m_errs++;
        if (m_errs >= 4) begin m_lock = 0; m_errs = 0; end
      end else m_errs = 0;
    end
  end

  task automatic check(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b at cycle %0d", req, act, exp, cycles);
    end
  endtask

  // every-cycle comparison against the reference
  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      check(tag, sync_n, m_lock);
      check(tag, lane_synced, m_lock);
    end
  end

  task automatic put(input bit v, input bit c, input logic [7:0] d, input bit e, input bit r);
    @(negedge clk);
    oct_vld = v; oct_ctl = c; oct_data = d; dec_err = e; resync_req = r;
  endtask
  task automatic comma(); put(1, 1, 8'hBC, 0, 0); endtask
  task automatic idle();  put(0, 0, 8'h00, 0, 0); endtask
  task automatic errd();  put(1, 0, 8'h55, 1, 0); endtask
  task automatic data(input logic [7:0] d); put(1, 0, d, 0, 0); endtask
  task automatic expect_now(input string req, input bit exp);
    @(negedge clk);
    check(req, sync_n, exp);
    check(req, lane_synced, exp);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      if (cycles > 100000) begin
        bad++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    rst_n = 0; oct_vld = 0; oct_ctl = 0; oct_data = 0; dec_err = 0; resync_req = 0;
    repeat (4) @(negedge clk);
    tag = "R1";
    check("R1", sync_n, 1'b0);
    check("R1", lane_synced, 1'b0);
    rst_n = 1;
    repeat (5) idle();
    expect_now("R1", 0);

    // R3 / R4: three commas then a break, stays low
    tag = "R4";
    repeat (3) comma();
    put(1, 1, 8'h1C, 0, 0);
    comma();
    data(8'h12);
    idle();
    expect_now("R4", 0);

    // R2: 0xBC without control flag or with error is not a comma
    tag = "R2";
    repeat (3) comma(); put(1, 0, 8'hBC, 0, 0);
    repeat (3) comma(); put(1, 1, 8'hBC, 1, 0);
    idle();
    expect_now("R2", 0);

    // R5 / R3: gaps inside the run do not break it
    tag = "R5";
    comma(); comma(); idle(); idle(); comma();
    tag = "R3";
    comma();
    idle();
    check("R3", sync_n, 1'b1);

    // R6: commas, alignment characters and data keep lock
    tag = "R6";
    repeat (3) comma();
    put(1, 1, 8'h1C, 0, 0); put(1, 1, 8'h7C, 0, 0);
    for (int i = 0; i < 20; i++) data(8'(i * 7));
    idle();
    expect_now("R6", 1);

    // R8: three errors then clean, twice; then run with a gap (R5) drops
    tag = "R8";
    repeat (3) errd(); data(8'h33);
    repeat (3) errd(); data(8'h44);
    idle();
    expect_now("R8", 1);
    errd(); idle(); errd(); errd();
    errd();
    idle();
    check("R8", sync_n, 1'b0);

    // R9: new full comma run needed
    tag = "R9";
    repeat (3) comma(); idle(); idle();
    expect_now("R9", 0);
    comma(); idle();
    check("R9", sync_n, 1'b1);

    // R7: re-sync drops, holds, ignores commas
    tag = "R7";
    put(1, 1, 8'hBC, 0, 1);
    idle();
    check("R7", sync_n, 1'b0);
    for (int i = 0; i < 6; i++) put(1, 1, 8'hBC, 0, 1);
    idle();
    check("R7", lane_synced, 1'b0);
    repeat (3) comma(); idle();
    check("R7", sync_n, 1'b0);
    comma(); idle();
    check("R7", sync_n, 1'b1);

    // mixed stream against the reference
    tag = "R3";
    for (int i = 0; i < 4000; i++) begin
      int k = $urandom_range(0, 99);
      if (k < 45)      comma();
      else if (k < 55) idle();
      else if (k < 75) errd();
      else if (k < 78) put(1, 1, 8'hBC, 0, 1);
      else if (k < 85) put(1, 1, 8'h1C, 0, 0);
      else             data(8'($urandom));
    end
    idle(); idle();

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule